// File: doc/BRIEF.md
# SDRAM power-up and refresh sequencer

This block owns the command pins of an SDR SDRAM from reset onward. It first raises clock enable and holds off for a start-up delay. It then runs a fixed bring-up order: precharge of every bank, two auto-refresh commands and a mode-register load. Each command is separated from the next by the timing gap that the memory needs. When bring-up is complete it raises `ready`, and the access logic may then use the memory.

After bring-up, a reloading interval counter produces refresh ticks. Ticks are accumulated in a small pending counter, so a tick that arrives while the access logic still holds the bus is not lost. While anything is pending the block raises `refreshReq` and holds it until the access logic answers with `refreshGack`. It then issues a burst of back-to-back auto-refresh commands, with `ready` low for the whole burst. The period and the burst length are runtime inputs. They are captured whenever the interval counter reloads.

The access logic can also put the memory into self-refresh by holding `selfRefReq`, using the same request and grant handshake. The block keeps clock enable low for at least the minimum self-refresh time and for as long as the request stays high. On exit it waits the self-refresh exit time, clears any pending ticks and restarts the interval counter.

Top module: `sdram_pwrup_refresh`

## Requirements
- R1: While `rstN` is low: `sdCke`=0, `sdCsN`=1, `sdRasN`=`sdCasN`=`sdWeN`=1, `ready`=0 and `refreshReq`=0.
- R2: `sdCke` goes high in the first cycle after reset is released. The bus then carries no command for exactly `StartupCycles` cycles. In the next cycle comes a precharge-all, encoded as CS#=0, RAS#=0, CAS#=1, WE#=0 with `sdAddr[10]`=1.
- R3: The first auto-refresh comes `TRp` (2) cycles after the precharge-all, and the second comes `TRc` (8) cycles after the first. Auto-refresh is encoded as CS#=0, RAS#=0, CAS#=0, WE#=1 with CKE high.
- R4: A mode-register load comes `TRc` cycles after the second auto-refresh. It is encoded as CS#=0, RAS#=0, CAS#=0, WE#=0 with `sdBa`=0 and `sdAddr`=0x0220. That value means: burst length 1 (bits 2:0 = 0), sequential (bit 3 = 0), CAS latency 2 (bits 6:4 = 2) and single-location writes (bit 9 = 1).
- R5: `ready` rises `TMrd` (2) cycles after the mode-register load. While `ready` is high the bus carries NOP.
- R6: Refresh ticks occur every `cfgInterval + RefreshOffset` cycles, counted from the cycle in which `ready` first rises. If `refreshGack` is returned in the cycle that follows `refreshReq`, the first auto-refresh of a burst comes `cfgInterval + RefreshOffset + 2` cycles after `ready` rises. Each later burst starts exactly one period after the previous one.
- R7: Each refresh burst issues `cfgBurst` auto-refresh commands (a value of 0 counts as 1), each `TRc` cycles after the previous one. `ready` is low from the first command of the burst until `TRc` cycles after its last command.
- R8: While a tick is pending and no grant has arrived, `refreshReq` stays high, `ready` stays high and the bus carries only NOP. Every tick missed this way produces its own full burst once grants arrive.
- R9: A new `cfgInterval` or `cfgBurst` has no effect on the period already being counted. It applies from the next reload of the interval counter, together with the burst that follows that reload.
- R10: Self-refresh entry is the auto-refresh encoding with `sdCke` low. `sdCke` stays low for at least `TRas` (5) cycles and until `selfRefReq` drops. `ready` rises `TXsr` (7) cycles after `sdCke` rises. The next refresh burst starts `cfgInterval + RefreshOffset + 2` cycles after `sdCke` rises.
- R11: No command other than the bring-up sequence, refresh bursts and self-refresh entry is ever driven. Every other cycle is NOP (CS#=0, RAS#=CAS#=WE#=1), and no read or write encoding ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the memory command bus |
| rstN | input | 1 | Active-low synchronous reset |
| cfgInterval | input | IntW | Refresh period minus `RefreshOffset`, in cycles |
| cfgBurst | input | BurstW | Auto-refresh commands per refresh event |
| refreshGack | input | 1 | Access logic releases the bus for a refresh or self-refresh |
| selfRefReq | input | 1 | Level request to stay in self-refresh |
| ready | output | 1 | Access logic may issue commands |
| refreshReq | output | 1 | Refresh or self-refresh wants the bus |
| sdCke | output | 1 | SDRAM clock enable |
| sdCsN | output | 1 | SDRAM chip select, active low |
| sdRasN | output | 1 | SDRAM row strobe, active low |
| sdCasN | output | 1 | SDRAM column strobe, active low |
| sdWeN | output | 1 | SDRAM write enable, active low |
| sdBa | output | BaW | SDRAM bank address |
| sdAddr | output | AddrW | SDRAM address / mode word |

## Verification
The refresh function is tried with three grant patterns.

- Immediate grants show whether ticks follow the programmed period, both before and after a mid-run change of period and burst length. This separates a change applied at once from one applied at the next reload.
- Withheld grants across two ticks show whether missed ticks are counted, rather than merged into one burst or dropped.
- A self-refresh request held only until entry checks the minimum low time of clock enable, the exit wait, and that the interval restarts on exit rather than continuing from before.

// File: rtl/sdrseq_pkg.sv
package sdrseq_pkg;
  typedef enum logic [2:0] {CMD_NOP, CMD_PALL, CMD_AREF, CMD_LMR, CMD_SELF} cmd_e;
  typedef enum logic [2:0] {GAP_START, GAP_RP, GAP_RC, GAP_MRD, GAP_RAS, GAP_XSR} gap_e;
  typedef struct packed {
    cmd_e cmd;
    logic cke;
    logic ready;
    logic req;
    logic loadGap;
    gap_e gapSel;
    logic reloadInt;
    logic takePend;
    logic clearPend;
    logic loadBurst;
    logic decBurst;
  } strobe_t;
endpackage

// File: rtl/sdrseq_ctrl.sv
module sdrseq_ctrl
  import sdrseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    gapZero,
  input  logic    pendNz,
  input  logic    burstZero,
  input  logic    reqOut,
  input  logic    refreshGack,
  input  logic    selfRefReq,
  output strobe_t strb
);
  typedef enum logic [3:0] {S_CKE, S_PALL, S_AR1, S_AR2, S_LMR, S_MRD,
                            S_IDLE, S_BURST, S_SELF, S_SXIT} state_e;
  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_CKE;
    else       state <= nextState;
  end

  always_comb begin
    strb = '0;
    strb.cmd = CMD_NOP;
    strb.cke = 1'b1;
    strb.gapSel = GAP_RC;
    nextState = state;
    case (state)
      S_CKE: begin
        strb.loadGap = 1'b1; strb.gapSel = GAP_START; nextState = S_PALL;
      end
      S_PALL: if (gapZero) begin
        strb.cmd = CMD_PALL; strb.loadGap = 1'b1; strb.gapSel = GAP_RP; nextState = S_AR1;
      end
      S_AR1: if (gapZero) begin
        strb.cmd = CMD_AREF; strb.loadGap = 1'b1; nextState = S_AR2;
      end
      S_AR2: if (gapZero) begin
        strb.cmd = CMD_AREF; strb.loadGap = 1'b1; nextState = S_LMR;
      end
      S_LMR: if (gapZero) begin
        strb.cmd = CMD_LMR; strb.loadGap = 1'b1; strb.gapSel = GAP_MRD; nextState = S_MRD;
      end
      S_MRD: if (gapZero) begin
        strb.reloadInt = 1'b1; strb.ready = 1'b1; nextState = S_IDLE;
      end
      S_IDLE: begin
        strb.ready = 1'b1;
        strb.req = pendNz || selfRefReq;
        if (reqOut && refreshGack) begin
          if (pendNz) begin
            strb = '0; strb.cke = 1'b1; strb.cmd = CMD_AREF; strb.gapSel = GAP_RC;
            strb.loadGap = 1'b1; strb.loadBurst = 1'b1; strb.takePend = 1'b1;
            nextState = S_BURST;
          end else if (selfRefReq) begin
            strb = '0; strb.cke = 1'b0; strb.cmd = CMD_SELF;
            strb.loadGap = 1'b1; strb.gapSel = GAP_RAS;
            nextState = S_SELF;
          end
        end
      end
      S_BURST: if (gapZero) begin
        if (burstZero) begin
          strb.ready = 1'b1; strb.req = pendNz || selfRefReq; nextState = S_IDLE;
        end else begin
          strb.cmd = CMD_AREF; strb.loadGap = 1'b1; strb.decBurst = 1'b1;
        end
      end
      S_SELF: begin
        strb.cke = 1'b0;
        if (gapZero && !selfRefReq) begin
          strb.cke = 1'b1; strb.loadGap = 1'b1; strb.gapSel = GAP_XSR;
          strb.clearPend = 1'b1; strb.reloadInt = 1'b1; nextState = S_SXIT;
        end
      end
      S_SXIT: if (gapZero) begin
        strb.ready = 1'b1; strb.req = pendNz || selfRefReq; nextState = S_IDLE;
      end
      default: nextState = S_CKE;
    endcase
  end

  // R3
  gap_respected_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmd != CMD_NOP) |-> gapZero);

  // R8
  req_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqOut && !refreshGack && pendNz) |=> reqOut);
endmodule

// File: rtl/sdrseq_datapath.sv
module sdrseq_datapath
  import sdrseq_pkg::*;
#(
  parameter int StartupCycles = 90000,
  parameter int TRp = 2,
  parameter int TRc = 8,
  parameter int TMrd = 2,
  parameter int TRas = 5,
  parameter int TXsr = 7,
  parameter int RefreshOffset = 20,
  parameter int IntW = 16,
  parameter int BurstW = 4,
  parameter int PendW = 3,
  parameter int AddrW = 13,
  parameter int BaW = 2,
  parameter logic [AddrW-1:0] ModeWord = 13'h0220
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [IntW-1:0]   cfgInterval,
  input  logic [BurstW-1:0] cfgBurst,
  output logic              gapZero,
  output logic              pendNz,
  output logic              burstZero,
  output logic              ready,
  output logic              refreshReq,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [BaW-1:0]    sdBa,
  output logic [AddrW-1:0]  sdAddr
);
  localparam int GapW = $clog2(StartupCycles + TXsr + TRc + TRas + 2);
  localparam int PerW = IntW + 1;
  localparam int AllBanksBit = 10;
  localparam logic [PendW-1:0] PendMax = '1;

  logic [GapW-1:0] gapCnt, gapLoad;
  always_comb begin
    case (strb.gapSel)
      GAP_START: gapLoad = GapW'(StartupCycles - 1);
      GAP_RP:    gapLoad = GapW'(TRp - 1);
      GAP_MRD:   gapLoad = GapW'(TMrd - 1);
      GAP_RAS:   gapLoad = GapW'(TRas - 1);
      GAP_XSR:   gapLoad = GapW'(TXsr - 1);
      default:   gapLoad = GapW'(TRc - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)              gapCnt <= '0;
    else if (strb.loadGap)  gapCnt <= gapLoad;
    else if (gapCnt != '0)  gapCnt <= gapCnt - 1'b1;
  end
  assign gapZero = (gapCnt == '0);

  logic [PerW-1:0] intCnt, reloadVal;
  logic [BurstW-1:0] burstCfgQ, burstClamp, burstRem;
  logic [PendW-1:0] pendCnt;
  logic running, tick, reloadNow;

  assign reloadVal  = {1'b0, cfgInterval} + PerW'(RefreshOffset - 1);
  assign burstClamp = (cfgBurst == '0) ? BurstW'(1) : cfgBurst;
  assign reloadNow  = strb.reloadInt || strb.clearPend;
  assign tick       = running && (intCnt == '0) && !reloadNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intCnt <= '0; running <= 1'b0; burstCfgQ <= BurstW'(1);
    end else if (reloadNow) begin
      intCnt <= reloadVal; running <= 1'b1; burstCfgQ <= burstClamp;
    end else if (running) begin
      if (intCnt == '0) begin
        intCnt <= reloadVal; burstCfgQ <= burstClamp;
      end else begin
        intCnt <= intCnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clearPend) pendCnt <= '0;
    else if (tick && !strb.takePend && pendCnt != PendMax) pendCnt <= pendCnt + 1'b1;
    else if (!tick && strb.takePend) pendCnt <= pendCnt - 1'b1;
  end
  assign pendNz = (pendCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN)               burstRem <= '0;
    else if (strb.loadBurst) burstRem <= burstCfgQ - 1'b1;
    else if (strb.decBurst)  burstRem <= burstRem - 1'b1;
  end
  assign burstZero = (burstRem == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdCke <= 1'b0; sdCsN <= 1'b1; {sdRasN, sdCasN, sdWeN} <= 3'b111;
      sdBa <= '0; sdAddr <= '0; ready <= 1'b0; refreshReq <= 1'b0;
    end else begin
      sdCke <= strb.cke; sdCsN <= 1'b0; sdBa <= '0;
      ready <= strb.ready; refreshReq <= strb.req;
      case (strb.cmd)
        CMD_PALL: begin {sdRasN, sdCasN, sdWeN} <= 3'b010; sdAddr <= AddrW'(1) << AllBanksBit; end
        CMD_AREF, CMD_SELF: begin {sdRasN, sdCasN, sdWeN} <= 3'b001; sdAddr <= '0; end
        CMD_LMR:  begin {sdRasN, sdCasN, sdWeN} <= 3'b000; sdAddr <= ModeWord; end
        default:  begin {sdRasN, sdCasN, sdWeN} <= 3'b111; sdAddr <= '0; end
      endcase
    end
  end

  logic [7:0] lowRun;
  logic everHigh;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowRun <= '0; everHigh <= 1'b0;
    end else begin
      if (sdCke) everHigh <= 1'b1;
      if (sdCke)               lowRun <= '0;
      else if (lowRun != 8'hff) lowRun <= lowRun + 1'b1;
    end
  end

  // R10
  self_min_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (everHigh && sdCke && !$past(sdCke)) |-> (lowRun >= 8'(TRas)));

  // R11
  no_rw_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sdCsN && sdRasN) |-> (sdCasN && sdWeN));

  // R5
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (!sdCsN && sdRasN && sdCasN && sdWeN));
endmodule

// File: rtl/sdram_pwrup_refresh.sv
module sdram_pwrup_refresh
  import sdrseq_pkg::*;
#(
  parameter int StartupCycles = 90000,
  parameter int TRp = 2,
  parameter int TRc = 8,
  parameter int TMrd = 2,
  parameter int TRas = 5,
  parameter int TXsr = 7,
  parameter int RefreshOffset = 20,
  parameter int IntW = 16,
  parameter int BurstW = 4,
  parameter int PendW = 3,
  parameter int AddrW = 13,
  parameter int BaW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IntW-1:0]   cfgInterval,
  input  logic [BurstW-1:0] cfgBurst,
  input  logic              refreshGack,
  input  logic              selfRefReq,
  output logic              ready,
  output logic              refreshReq,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [BaW-1:0]    sdBa,
  output logic [AddrW-1:0]  sdAddr
);
  strobe_t strb;
  logic gapZero, pendNz, burstZero;

  sdrseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .gapZero(gapZero), .pendNz(pendNz),
    .burstZero(burstZero), .reqOut(refreshReq), .refreshGack(refreshGack),
    .selfRefReq(selfRefReq), .strb(strb)
  );

  sdrseq_datapath #(
    .StartupCycles(StartupCycles), .TRp(TRp), .TRc(TRc), .TMrd(TMrd),
    .TRas(TRas), .TXsr(TXsr), .RefreshOffset(RefreshOffset), .IntW(IntW),
    .BurstW(BurstW), .PendW(PendW), .AddrW(AddrW), .BaW(BaW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgInterval(cfgInterval),
    .cfgBurst(cfgBurst), .gapZero(gapZero), .pendNz(pendNz),
    .burstZero(burstZero), .ready(ready), .refreshReq(refreshReq),
    .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN),
    .sdWeN(sdWeN), .sdBa(sdBa), .sdAddr(sdAddr)
  );
endmodule

// File: tb/tb_sdram_pwrup_refresh.sv
`timescale 1ns/1ps
module tb_sdram_pwrup_refresh;
  localparam int STARTUP = 50;
  localparam int OFF = 20;
  localparam int TRC = 8;
  localparam int P1 = 100 + OFF;
  localparam int P2 = 60 + OFF;
  localparam int C_NOP = 0, C_PALL = 1, C_AREF = 2, C_LMR = 3, C_SELF = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic [15:0] cfgInterval = 16'd100;
  logic [3:0] cfgBurst = 4'd3;
  logic refreshGack = 1'b0, selfRefReq = 1'b0, autoGrant = 1'b0;
  logic ready, refreshReq, sdCke, sdCsN, sdRasN, sdCasN, sdWeN;
  logic [1:0] sdBa;
  logic [12:0] sdAddr;

  sdram_pwrup_refresh #(.StartupCycles(STARTUP)) dut (
    .clk(clk), .rstN(rstN), .cfgInterval(cfgInterval), .cfgBurst(cfgBurst),
    .refreshGack(refreshGack), .selfRefReq(selfRefReq), .ready(ready),
    .refreshReq(refreshReq), .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN),
    .sdCasN(sdCasN), .sdWeN(sdWeN), .sdBa(sdBa), .sdAddr(sdAddr)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  typedef struct { int code; int gap; string tag; } exp_t;
  exp_t q[$];
  task automatic push(input int code, input int gap, input string tag);
    exp_t e;
    e.code = code; e.gap = gap; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) refreshGack <= autoGrant & refreshReq;

  int lastCmd = 0, arefCount = 0, lastAref = 0, lmrCyc = 0;
  int ckeRise = -1, ckeFall = -1;
  bit ckePrev = 1'b0, firstRise = 1'b1;
  always @(negedge clk) begin
    if (rstN) begin
      int code;
      exp_t e;
      if (sdCke && !ckePrev) begin
        ckeRise = cyc;
        if (firstRise) begin lastCmd = cyc; firstRise = 1'b0; end
      end
      if (!sdCke && ckePrev) ckeFall = cyc;
      ckePrev = sdCke;
      if (sdCsN || {sdRasN, sdCasN, sdWeN} == 3'b111) code = C_NOP;
      else if ({sdRasN, sdCasN, sdWeN} == 3'b010) code = C_PALL;
      else if ({sdRasN, sdCasN, sdWeN} == 3'b001) code = sdCke ? C_AREF : C_SELF;
      else if ({sdRasN, sdCasN, sdWeN} == 3'b000) code = C_LMR;
      else code = 9;
      if (code != C_NOP) begin
        if (q.size() == 0) begin
          chk(1'b0, "R11 unexpected command", code, C_NOP);
        end else begin
          e = q.pop_front();
          chk(code == e.code, {e.tag, " command"}, code, e.code);
          if (e.gap >= 0) chk(cyc - lastCmd == e.gap, {e.tag, " gap"}, cyc - lastCmd, e.gap);
          if (code == C_PALL) chk(sdAddr[10] == 1'b1, "R2 precharge A10", int'(sdAddr[10]), 1);
          if (code == C_LMR) chk(sdAddr == 13'h0220 && sdBa == 2'd0, "R4 mode word",
                                 int'({sdBa, sdAddr}), 32'h220);
        end
        lastCmd = cyc;
        if (code == C_AREF) begin arefCount++; lastAref = cyc; end
        if (code == C_LMR) lmrCyc = cyc;
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  bit done = 1'b0;
  initial begin
    int rel, rdy, l4, fa;
    push(C_PALL, STARTUP, "R2 precharge");
    push(C_AREF, 2, "R3 first refresh");
    push(C_AREF, TRC, "R3 second refresh");
    push(C_LMR, TRC, "R4 mode load");
    push(C_AREF, -1, "R6 burst1"); push(C_AREF, TRC, "R7 burst1"); push(C_AREF, TRC, "R7 burst1");
    push(C_AREF, P1 - 2*TRC, "R6 burst2"); push(C_AREF, TRC, "R7 burst2"); push(C_AREF, TRC, "R7 burst2");
    push(C_AREF, P1 - 2*TRC, "R9 burst3 old period"); push(C_AREF, TRC, "R9 burst3 new count");
    push(C_AREF, P2 - TRC, "R9 burst4 new period"); push(C_AREF, TRC, "R9 burst4");

    repeat (3) step();
    // R1 reset state
    chk(sdCke == 0, "R1 cke", sdCke, 0);
    chk(sdCsN == 1 && {sdRasN, sdCasN, sdWeN} == 3'b111, "R1 bus", int'({sdCsN, sdRasN, sdCasN, sdWeN}), 15);
    chk(ready == 0 && refreshReq == 0, "R1 ready/req", int'({ready, refreshReq}), 0);

    @(negedge clk); rstN = 1'b1; #1; rel = cyc;
    autoGrant = 1'b1;
    step();
    chk(sdCke == 1 && ckeRise == rel + 1, "R2 cke first", ckeRise, rel + 1);
    while (!ready) step();
    rdy = cyc;
    chk(rdy - lmrCyc == 2, "R5 ready after mode load", rdy - lmrCyc, 2);
    while (arefCount < 3) step();
    chk(lastAref - rdy == P1 + 2, "R6 first tick", lastAref - rdy, P1 + 2);
    while (arefCount < 6) step();
    cfgInterval = 16'd60; cfgBurst = 4'd2;
    while (arefCount < 12) step();
    l4 = lastAref;
    autoGrant = 1'b0;
    while (cyc < l4 + 100) step();
    // R8 request held, no commands while withheld
    chk(refreshReq == 1, "R8 req held", refreshReq, 1);
    chk(ready == 1, "R8 ready while waiting", ready, 1);
    while (cyc < l4 + 161) step();
    chk(refreshReq == 1, "R8 req still held", refreshReq, 1);
    push(C_AREF, -1, "R8 missed tick A"); push(C_AREF, TRC, "R8 missed tick A");
    push(C_AREF, -1, "R8 missed tick B"); push(C_AREF, TRC, "R8 missed tick B");
    autoGrant = 1'b1;
    while (arefCount < 16) step();
    repeat (10) step();
    chk(ready == 1 && refreshReq == 0, "R8 all ticks served", int'({ready, refreshReq}), 2);

    push(C_SELF, -1, "R10 self entry");
    push(C_AREF, -1, "R10 refresh after exit"); push(C_AREF, TRC, "R10 refresh after exit");
    selfRefReq = 1'b1;
    while (sdCke) step();
    selfRefReq = 1'b0;
    while (!sdCke) step();
    chk(ckeRise - ckeFall == 5, "R10 min low time", ckeRise - ckeFall, 5);
    while (!ready) step();
    chk(cyc - ckeRise == 7, "R10 exit wait", cyc - ckeRise, 7);
    fa = arefCount;
    while (arefCount == fa) step();
    chk(lastAref - ckeRise == P2 + 2, "R10 interval restart", lastAref - ckeRise, P2 + 2);
    while (arefCount < fa + 2) step();
    repeat (20) step();
    chk(q.size() == 0, "R11 all expected commands seen", q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R11 actual=%0d expected=%0d", q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule